// File: doc/BRIEF.md
# Software-Advanced Result-Return Pipeline

This block models the result path of an arithmetic unit whose stages move only when an operation is issued to them. Issuing a pipelined operation does three things in one cycle. It hands back the entry sitting at the last stage in use. It shifts the occupied stages forward by one. It loads the new operands into the first stage. A run of same-precision operations therefore returns the result of the operation issued one, two or three issues earlier. The depth depends on the precision of the issue. The arithmetic is modelled as an unsigned integer product, and the block keeps the low half of it.

A scalar operation is accepted only when the block is idle. It discards whatever the stages held, walks through every stage of its depth, and reports its own result, with the ready output low while it runs. Each stage carries a private copy of the result-status bits. Software can load an override status into the first stage, and that override rides forward with the data. When it is returned, it replaces the status computed from the result. A returned status with an exception bit set raises a trap flag alongside the next returned result. A pipelined issue can also take the value it is returning as either of its own operands.

Top module: `result_return_pipe`

## Requirements
- R1: While reset is held and in the first cycle after it, result_valid and exc_trap are 0 and op_ready is 1.
- R2: A pipelined issue (op_valid and op_ready high, op_scalar low) sets result_valid in the next cycle. result then carries the entry held at the issue's depth, which is the low 32 bits of src1*src2 of the operation that filled that stage, or the value given in R4. Stages 1..depth-1 shift forward and stage 1 takes the new operands. result_valid is low in cycles with nothing returned, and result holds its value in those cycles.
- R3: Depth comes from op_prec: 2'b00 (single) gives 3, 2'b01 (double) gives 2, 2'b10 (integer) gives 1, 2'b11 gives 3. With parameter ADDER_MODE set, every precision gives 3.
- R4: An empty stage returns result 0 and status 4'b0000, unless it carries an injected status. A stage is empty after reset, and after a scalar operation every stage is empty.
- R5: A scalar issue with depth d drops op_ready in the next cycle. It presents result_valid with its own product and computed status d cycles after acceptance, and op_ready rises in that same cycle. Entries not yet returned are lost. op_fwd1 and op_fwd2 have no effect on a scalar issue.
- R6: While op_ready is low, op_valid and stat_load are ignored. No operation is accepted and no status is injected.
- R7: Computed status bits: [0] the low half is zero; [1] bit 31 of the low half; [2] the high half of the product is non-zero; [3] both operands are non-zero and the low half is zero.
- R8: stat_load with stat_update high, while op_ready is high and no scalar is being accepted, writes stat_value as an override into stage 1. If a pipelined issue happens in the same cycle, the override attaches to the newly loaded entry. The override travels with its entry, and the status returned for that entry is the override. stat_load with stat_update low does nothing.
- R9: result_prec is the op_prec of the issue that started the returned operation, or 2'b00 for an empty stage.
- R10: exc_trap is 1 together with result_valid of the next returned result after a returned status that has bit 2 or bit 3 set. Otherwise it is 0.
- R11: On a pipelined issue, op_fwd1 (op_fwd2) replaces src1 (src2) with the result value being returned by that same issue.
- R12: A pipelined issue of depth d leaves the stages deeper than d unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation request |
| op_ready | output | 1 | Block can accept an operation or status load |
| op_scalar | input | 1 | 1 = scalar operation, 0 = pipelined |
| op_prec | input | 2 | Source precision code, selects depth |
| op_src1 | input | 32 | First operand |
| op_src2 | input | 32 | Second operand |
| op_fwd1 | input | 1 | Use the returned value as first operand |
| op_fwd2 | input | 1 | Use the returned value as second operand |
| stat_load | input | 1 | Status write strobe |
| stat_update | input | 1 | Status write targets stage 1 |
| stat_value | input | 4 | Override status value |
| result_valid | output | 1 | A result is presented this cycle |
| result | output | 32 | Returned value |
| result_prec | output | 2 | Precision of the returned operation |
| result_status | output | 4 | Returned status |
| exc_trap | output | 1 | Previous returned status held an exception |

## Verification
A pipelined result is due in the cycle after the accepting edge. A scalar result is due exactly d cycles after acceptance, in the same cycle that op_ready returns. A trap is due with the result that follows the flagged one. The bench drives inputs on falling edges and steps a behavioural model of the stage contents on each rising edge. On every falling edge it compares result_valid, op_ready and exc_trap, and in cycles where a result is due it also compares the value, precision and status, so any result that arrives early or late is reported.

// File: rtl/rrp_pkg.sv
package rrp_pkg;

    localparam int RRP_DW  = 32;
    localparam int RRP_SW  = 4;
    localparam int RRP_NST = 3;

    typedef logic [RRP_DW-1:0] word_t;
    typedef logic [RRP_SW-1:0] stat_t;

    typedef enum logic [1:0] {
        PREC_SINGLE = 2'b00,
        PREC_DOUBLE = 2'b01,
        PREC_INT    = 2'b10,
        PREC_WIDE   = 2'b11
    } prec_e;

    typedef enum logic {
        FSM_IDLE = 1'b0,
        FSM_WALK = 1'b1
    } fsm_e;

    typedef struct packed {
        logic       live;
        logic [1:0] prec;
        word_t      a;
        word_t      b;
        logic       inj;
        stat_t      inj_stat;
    } entry_t;

    localparam entry_t ENTRY_EMPTY = '0;
    localparam stat_t  EXC_MASK    = 4'b1100;

    function automatic logic [1:0] depth_of(input logic [1:0] prec, input logic adder);
        logic [1:0] d;
        if (adder) begin
            d = 2'd3;
        end else begin
            unique case (prec_e'(prec))
                PREC_DOUBLE: d = 2'd2;
                PREC_INT:    d = 2'd1;
                default:     d = 2'd3;
            endcase
        end
        return d;
    endfunction

    function automatic logic [2*RRP_DW-1:0] product(input entry_t e);
        return {{RRP_DW{1'b0}}, e.a} * {{RRP_DW{1'b0}}, e.b};
    endfunction

    function automatic word_t calc_result(input entry_t e);
        logic [2*RRP_DW-1:0] p;
        p = product(e);
        return e.live ? p[RRP_DW-1:0] : '0;
    endfunction

    function automatic stat_t calc_status(input entry_t e);
        logic [2*RRP_DW-1:0] p;
        stat_t s;
        p = product(e);
        s = '0;
        if (e.inj) begin
            s = e.inj_stat;
        end else if (e.live) begin
            s[0] = (p[RRP_DW-1:0] == '0);
            s[1] = p[RRP_DW-1];
            s[2] = (p[2*RRP_DW-1:RRP_DW] != '0);
            s[3] = (e.a != '0) && (e.b != '0) && (p[RRP_DW-1:0] == '0);
        end
        return s;
    endfunction

endpackage

// File: rtl/rrp_issue_fsm.sv
module rrp_issue_fsm
    import rrp_pkg::*;
#(
    parameter bit ADDER_MODE = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       op_valid,
    input  logic       op_scalar,
    input  logic [1:0] op_prec,
    output logic       op_ready,
    output logic       acc_pipe,
    output logic       acc_scalar,
    output logic       walk_shift,
    output logic       walk_done,
    output logic [1:0] iss_depth,
    output logic [1:0] sc_depth
);

    fsm_e       state_q, state_d;
    logic [1:0] cnt_q, cnt_d;
    logic [1:0] scd_q, scd_d;
    logic [1:0] req_depth;

    assign req_depth = depth_of(op_prec, ADDER_MODE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FSM_IDLE;
            cnt_q   <= '0;
            scd_q   <= 2'd3;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            scd_q   <= scd_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        scd_d   = scd_q;
        unique case (state_q)
            FSM_IDLE: begin
                if (op_valid && op_scalar) begin
                    state_d = FSM_WALK;
                    cnt_d   = req_depth;
                    scd_d   = req_depth;
                end
            end
            FSM_WALK: begin
                if (cnt_q == 2'd1) begin
                    state_d = FSM_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q - 2'd1;
                end
            end
            default: state_d = FSM_IDLE;
        endcase
    end

    always_comb begin
        op_ready   = (state_q == FSM_IDLE);
        acc_pipe   = (state_q == FSM_IDLE) && op_valid && !op_scalar;
        acc_scalar = (state_q == FSM_IDLE) && op_valid && op_scalar;
        walk_shift = (state_q == FSM_WALK) && (cnt_q != 2'd1);
        walk_done  = (state_q == FSM_WALK) && (cnt_q == 2'd1);
        iss_depth  = req_depth;
        sc_depth   = scd_q;
    end

endmodule

// File: rtl/rrp_stage_chain.sv
module rrp_stage_chain
    import rrp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc_pipe,
    input  logic       acc_scalar,
    input  logic       walk_shift,
    input  logic       walk_done,
    input  logic [1:0] iss_depth,
    input  logic [1:0] sc_depth,
    input  entry_t     new_entry,
    input  logic       inj_en,
    input  stat_t      inj_val,
    output entry_t     ret_entry
);

    entry_t     st_q [RRP_NST];
    logic [1:0] ret_sel;

    for (genvar k = 0; k < RRP_NST; k++) begin : g_stage
        entry_t prev;
        entry_t nxt;
        entry_t q;

        if (k == 0) begin : g_head
            assign prev = new_entry;
        end else begin : g_body
            assign prev = st_q[k-1];
        end

        always_comb begin
            nxt = q;
            if (acc_scalar) begin
                nxt = (k == 0) ? new_entry : ENTRY_EMPTY;
            end else if (walk_done) begin
                nxt = ENTRY_EMPTY;
            end else if (walk_shift) begin
                nxt = (k == 0) ? ENTRY_EMPTY : prev;
            end else if (acc_pipe && (int'(iss_depth) > k)) begin
                nxt = prev;
            end
            if ((k == 0) && inj_en) begin
                nxt.inj      = 1'b1;
                nxt.inj_stat = inj_val;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= ENTRY_EMPTY;
            else        q <= nxt;
        end

        assign st_q[k] = q;
    end

    assign ret_sel = acc_pipe ? iss_depth : sc_depth;

    always_comb begin
        ret_entry = st_q[RRP_NST-1];
        for (int i = 0; i < RRP_NST; i++) begin
            if (int'(ret_sel) == i + 1) ret_entry = st_q[i];
        end
    end

endmodule

// File: rtl/rrp_return_unit.sv
module rrp_return_unit
    import rrp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fire,
    input  entry_t     ret_entry,
    output logic       result_valid,
    output word_t      result,
    output logic [1:0] result_prec,
    output stat_t      result_status,
    output logic       exc_trap
);

    stat_t ret_stat;
    logic  pend_q;

    assign ret_stat = calc_status(ret_entry);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_valid  <= 1'b0;
            result        <= '0;
            result_prec   <= '0;
            result_status <= '0;
            exc_trap      <= 1'b0;
            pend_q        <= 1'b0;
        end else begin
            result_valid <= fire;
            exc_trap     <= fire && pend_q;
            if (fire) begin
                result        <= calc_result(ret_entry);
                result_prec   <= ret_entry.prec;
                result_status <= ret_stat;
                pend_q        <= |(ret_stat & EXC_MASK);
            end
        end
    end

endmodule

// File: rtl/result_return_pipe.sv
module result_return_pipe
    import rrp_pkg::*;
#(
    parameter bit ADDER_MODE = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        op_valid,
    output logic        op_ready,
    input  logic        op_scalar,
    input  logic [1:0]  op_prec,
    input  logic [31:0] op_src1,
    input  logic [31:0] op_src2,
    input  logic        op_fwd1,
    input  logic        op_fwd2,
    input  logic        stat_load,
    input  logic        stat_update,
    input  logic [3:0]  stat_value,
    output logic        result_valid,
    output logic [31:0] result,
    output logic [1:0]  result_prec,
    output logic [3:0]  result_status,
    output logic        exc_trap
);

    logic       acc_pipe, acc_scalar, walk_shift, walk_done, inj_en;
    logic [1:0] iss_depth, sc_depth;
    entry_t     ret_entry, new_entry;
    word_t      ret_word;

    rrp_issue_fsm #(.ADDER_MODE(ADDER_MODE)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_valid   (op_valid),
        .op_scalar  (op_scalar),
        .op_prec    (op_prec),
        .op_ready   (op_ready),
        .acc_pipe   (acc_pipe),
        .acc_scalar (acc_scalar),
        .walk_shift (walk_shift),
        .walk_done  (walk_done),
        .iss_depth  (iss_depth),
        .sc_depth   (sc_depth)
    );

    assign ret_word = calc_result(ret_entry);
    assign inj_en   = op_ready && stat_load && stat_update && !acc_scalar;

    always_comb begin
        new_entry          = ENTRY_EMPTY;
        new_entry.live     = 1'b1;
        new_entry.prec     = op_prec;
        new_entry.a        = (op_fwd1 && !op_scalar) ? ret_word : op_src1;
        new_entry.b        = (op_fwd2 && !op_scalar) ? ret_word : op_src2;
    end

    rrp_stage_chain u_chain (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_pipe   (acc_pipe),
        .acc_scalar (acc_scalar),
        .walk_shift (walk_shift),
        .walk_done  (walk_done),
        .iss_depth  (iss_depth),
        .sc_depth   (sc_depth),
        .new_entry  (new_entry),
        .inj_en     (inj_en),
        .inj_val    (stat_value),
        .ret_entry  (ret_entry)
    );

    rrp_return_unit u_ret (
        .clk           (clk),
        .rst_n         (rst_n),
        .fire          (acc_pipe || walk_done),
        .ret_entry     (ret_entry),
        .result_valid  (result_valid),
        .result        (result),
        .result_prec   (result_prec),
        .result_status (result_status),
        .exc_trap      (exc_trap)
    );

endmodule

// File: rtl/result_return_pipe_chk.sv
module result_return_pipe_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        op_valid,
    input logic        op_ready,
    input logic        op_scalar,
    input logic        result_valid,
    input logic [31:0] result,
    input logic        exc_trap
);

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> !result_valid && !exc_trap && op_ready); // R1

    AST_PIPE_RETURNS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_ready && !op_scalar |=> result_valid); // R2

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid |-> $stable(result)); // R2

    AST_SCALAR_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_ready && op_scalar |=> !op_ready); // R5

    AST_SCALAR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(op_ready) |-> result_valid); // R5

    AST_TRAP_WITH_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        exc_trap |-> result_valid); // R10

endmodule

bind result_return_pipe result_return_pipe_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_valid     (op_valid),
    .op_ready     (op_ready),
    .op_scalar    (op_scalar),
    .result_valid (result_valid),
    .result       (result),
    .exc_trap     (exc_trap)
);

// File: tb/result_return_pipe_bench.sv
module result_return_pipe_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0, op_scalar = 1'b0, op_fwd1 = 1'b0, op_fwd2 = 1'b0;
    logic [1:0]  op_prec = 2'b00;
    logic [31:0] op_src1 = '0, op_src2 = '0;
    logic        stat_load = 1'b0, stat_update = 1'b0;
    logic [3:0]  stat_value = '0;
    logic        op_ready, result_valid, exc_trap;
    logic [31:0] result;
    logic [1:0]  result_prec;
    logic [3:0]  result_status;

    always #5 clk = ~clk;

    result_return_pipe u_result_return_pipe (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
        .op_scalar(op_scalar), .op_prec(op_prec), .op_src1(op_src1), .op_src2(op_src2),
        .op_fwd1(op_fwd1), .op_fwd2(op_fwd2), .stat_load(stat_load),
        .stat_update(stat_update), .stat_value(stat_value), .result_valid(result_valid),
        .result(result), .result_prec(result_prec), .result_status(result_status),
        .exc_trap(exc_trap)
    );

    int    n_chk = 0, n_fail = 0;
    string cur_req = "R1";

    // behavioural model state
    logic        ml [3];
    logic [31:0] ma [3], mb [3];
    logic [1:0]  mp [3];
    logic        mi [3];
    logic [3:0]  ms [3];
    int          busy;
    logic        pend;
    logic [31:0] sc_r;
    logic [3:0]  sc_s;
    logic [1:0]  sc_p;
    logic        exp_valid, exp_ready, exp_trap;
    logic [31:0] exp_res;
    logic [3:0]  exp_st;
    logic [1:0]  exp_prec;

    function automatic int bdepth(input logic [1:0] p);
        if (p == 2'b01) return 2;
        if (p == 2'b10) return 1;
        return 3;
    endfunction

    function automatic logic [31:0] bres(input logic live, input logic [31:0] a, input logic [31:0] b);
        logic [63:0] p;
        p = 64'(a) * 64'(b);
        return live ? p[31:0] : 32'h0;
    endfunction

    function automatic logic [3:0] bstat(input logic live, input logic inj, input logic [3:0] ist,
                                         input logic [31:0] a, input logic [31:0] b);
        logic [63:0] p;
        logic [3:0]  s;
        p = 64'(a) * 64'(b);
        if (inj) return ist;
        if (!live) return 4'h0;
        s[0] = (p[31:0] == 0);
        s[1] = p[31];
        s[2] = (p[63:32] != 0);
        s[3] = (a != 0) && (b != 0) && (p[31:0] == 0);
        return s;
    endfunction

    task automatic clear_model();
        for (int k = 0; k < 3; k++) begin
            ml[k] = 0; ma[k] = 0; mb[k] = 0; mp[k] = 0; mi[k] = 0; ms[k] = 0;
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            clear_model();
            busy = 0; pend = 0;
            exp_valid = 0; exp_trap = 0; exp_ready = 1;
            exp_res = 0; exp_st = 0; exp_prec = 0;
        end else begin
            exp_valid = 0;
            exp_trap  = 0;
            if (busy != 0) begin
                if (busy == 1) begin
                    exp_valid = 1; exp_res = sc_r; exp_st = sc_s; exp_prec = sc_p;
                    exp_trap = pend; pend = |(sc_s & 4'hC);
                    clear_model();
                    busy = 0;
                end else begin
                    busy = busy - 1;
                end
            end else if (op_valid && op_scalar) begin
                sc_r = bres(1'b1, op_src1, op_src2);
                sc_s = bstat(1'b1, 1'b0, 4'h0, op_src1, op_src2);
                sc_p = op_prec;
                clear_model();
                busy = bdepth(op_prec);
            end else begin
                if (op_valid) begin
                    int d;
                    logic [31:0] r;
                    logic [3:0]  s;
                    d = bdepth(op_prec);
                    r = bres(ml[d-1], ma[d-1], mb[d-1]);
                    s = bstat(ml[d-1], mi[d-1], ms[d-1], ma[d-1], mb[d-1]);
                    exp_valid = 1; exp_res = r; exp_st = s; exp_prec = mp[d-1];
                    exp_trap = pend; pend = |(s & 4'hC);
                    for (int k = d - 1; k > 0; k--) begin
                        ml[k] = ml[k-1]; ma[k] = ma[k-1]; mb[k] = mb[k-1];
                        mp[k] = mp[k-1]; mi[k] = mi[k-1]; ms[k] = ms[k-1];
                    end
                    ml[0] = 1; ma[0] = op_fwd1 ? r : op_src1; mb[0] = op_fwd2 ? r : op_src2;
                    mp[0] = op_prec; mi[0] = 0; ms[0] = 0;
                end
                if (stat_load && stat_update) begin
                    mi[0] = 1; ms[0] = stat_value;
                end
            end
            exp_ready = (busy == 0);
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s [%s] actual=%0h expected=%0h at %0t", tag, cur_req, act, exp, $time);
        end
    endtask

    // compare on every falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 result_valid", 32'(result_valid), 32'(exp_valid));
            chk("R5 op_ready", 32'(op_ready), 32'(exp_ready));
            chk("R10 exc_trap", 32'(exc_trap), 32'(exp_trap));
            if (exp_valid) begin
                chk("R2 result", result, exp_res);
                chk("R7 status", 32'(result_status), 32'(exp_st));
                chk("R9 prec", 32'(result_prec), 32'(exp_prec));
            end
        end
    end

    task automatic op(input logic sc, input logic [1:0] pr, input logic [31:0] a, input logic [31:0] b,
                      input logic f1 = 0, input logic f2 = 0, input logic sl = 0,
                      input logic su = 0, input logic [3:0] sv = 0);
        @(negedge clk);
        op_valid = 1; op_scalar = sc; op_prec = pr; op_src1 = a; op_src2 = b;
        op_fwd1 = f1; op_fwd2 = f2; stat_load = sl; stat_update = su; stat_value = sv;
    endtask

    task automatic stat_only(input logic su, input logic [3:0] sv);
        @(negedge clk);
        op_valid = 0; op_scalar = 0; op_fwd1 = 0; op_fwd2 = 0;
        stat_load = 1; stat_update = su; stat_value = sv;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            op_valid = 0; op_scalar = 0; op_fwd1 = 0; op_fwd2 = 0;
            stat_load = 0; stat_update = 0;
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog [%s] actual=timeout expected=finish", cur_req);
        summary();
        $finish;
    end

    initial begin
        logic [31:0] lf;
        repeat (3) @(posedge clk);
        @(negedge clk);
        cur_req = "R1";
        chk("R1 reset valid", 32'(result_valid), 0);
        chk("R1 reset ready", 32'(op_ready), 1);
        chk("R1 reset trap", 32'(exc_trap), 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 post-reset valid", 32'(result_valid), 0);

        cur_req = "R3";   // single precision: third prior result; first returns empty (R4)
        op(0, 2'b00, 3, 5); op(0, 2'b00, 7, 11); op(0, 2'b00, 13, 17);
        op(0, 2'b00, 19, 23); op(0, 2'b00, 0, 0); op(0, 2'b00, 0, 0); op(0, 2'b00, 0, 0);
        idle(2);
        op(0, 2'b01, 2, 9); op(0, 2'b01, 4, 9); op(0, 2'b01, 6, 9); op(0, 2'b01, 8, 9);
        idle(1);
        op(0, 2'b10, 10, 3); op(0, 2'b10, 20, 3); op(0, 2'b10, 30, 3);
        op(0, 2'b11, 1, 1); op(0, 2'b11, 2, 2); op(0, 2'b11, 3, 3); op(0, 2'b11, 4, 4);
        idle(2);

        cur_req = "R12";  // shallower issues must not disturb stage 3
        op(0, 2'b00, 100, 1); op(0, 2'b00, 200, 1); op(0, 2'b00, 300, 1);
        op(0, 2'b01, 5, 5); op(0, 2'b10, 6, 6); op(0, 2'b01, 7, 7);
        op(0, 2'b00, 0, 0); op(0, 2'b00, 0, 0); op(0, 2'b00, 0, 0);

        cur_req = "R7";
        op(0, 2'b01, 32'h0001_0000, 32'h0001_0000);
        op(0, 2'b01, 32'hFFFF_FFFF, 2);
        op(0, 2'b01, 0, 5);
        op(0, 2'b01, 32'h4000_0000, 2);
        cur_req = "R10";
        op(0, 2'b01, 1, 1); op(0, 2'b01, 1, 1); op(0, 2'b01, 1, 1);
        idle(2);

        cur_req = "R8";
        stat_only(0, 4'hF);          // no update bit: ignored
        op(0, 2'b00, 9, 9); op(0, 2'b00, 9, 9); op(0, 2'b00, 9, 9);
        stat_only(1, 4'h4);          // override into stage 1
        op(0, 2'b00, 1, 2); op(0, 2'b00, 1, 3);
        op(0, 2'b00, 1, 4, 0, 0, 1, 1, 4'h8); // override on newly loaded entry
        op(0, 2'b00, 0, 0); op(0, 2'b00, 0, 0); op(0, 2'b00, 0, 0);
        idle(2);

        cur_req = "R11";
        op(0, 2'b10, 6, 7);
        op(0, 2'b10, 0, 2, 1, 0);
        op(0, 2'b10, 3, 0, 0, 1);
        op(0, 2'b10, 0, 0, 1, 1);
        op(0, 2'b10, 0, 0);
        idle(2);

        cur_req = "R5";
        op(0, 2'b00, 11, 11); op(0, 2'b00, 12, 12);
        op(1, 2'b00, 21, 2, 1, 1); idle(5);
        op(1, 2'b01, 32'h8000_0000, 3); idle(4);
        op(1, 2'b10, 5, 5); idle(3);
        cur_req = "R4";
        op(0, 2'b00, 1, 1); op(0, 2'b00, 1, 1); op(0, 2'b00, 1, 1); op(0, 2'b00, 1, 1);
        idle(2);

        cur_req = "R6";
        op(1, 2'b00, 8, 8);
        op(0, 2'b10, 44, 44); op(0, 2'b10, 45, 45, 0, 0, 1, 1, 4'hC);
        stat_only(1, 4'hC);
        op(0, 2'b10, 46, 46); op(0, 2'b10, 47, 47);
        idle(3);

        cur_req = "R2";
        lf = 32'h1234_5678;
        for (int i = 0; i < 800; i++) begin
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
            if (lf[7:0] < 8'd12)      op(1, lf[9:8], lf, {lf[15:0], lf[31:16]});
            else if (lf[7:0] < 8'd40) stat_only(lf[10], lf[14:11]);
            else if (lf[7:0] < 8'd60) idle(1);
            else op(0, lf[9:8], {16'h0, lf[31:16]}, {lf[27:12]} & 32'h0003_FFFF,
                    lf[11], lf[12], lf[13], lf[14], lf[18:15]);
        end
        idle(6);

        summary();
        $finish;
    end

endmodule